// File: doc/BRIEF.md
# Serial Coefficient Stream Unpacker

This block sits between a forward block transform that emits a compressed one-bit serial stream and an inverse transform that consumes one parallel coefficient per clock. Each compressed block is 64 serial bits: eight low-frequency coefficients of eight bits each. The bits arrive most-significant bit first, and the coefficients arrive in ascending block position. A start marker is high on the cycle that carries the first bit. The block rebuilds a full 64-position coefficient block at 12-bit width. The eight carried values go to their original positions and every other position is driven to zero.

Collection and playback use two register banks in turn. One bank fills from the serial stream while the other drains to the output, so output blocks can follow one another with no idle cycle. The stream runs at a fixed rate of one bit and one coefficient per clock. Neither side can stall, so there is no back-pressure and no handshake. A static mode pin chooses how each 8-bit value widens to 12 bits: sign extension, or a left shift by four.

Top module: `coef_unpack`

## Requirements
- R1: After reset, `blk_start_o` stays 0 and `coef_o` stays 0 until a full 64-bit serial block has been received.
- R2: Serial bit k of a block (k = 0 on the cycle `ser_start_i` is high) is bit 7 − (k mod 8) of carried value k div 8. The carried values 0..7 land at block positions 0, 1, 2, 8, 9, 10, 16 and 17 in that order.
- R3: The block's output occupies 64 consecutive cycles, one position per cycle in ascending order. Position 0 appears exactly 64 cycles after the cycle in which `ser_start_i` was high. `blk_start_o` is high on position 0 only.
- R4: Every output position outside the carried set is 0.
- R5: With `scale_i` = 0, a carried value is sign-extended from bit 7 to 12 bits.
- R6: With `scale_i` = 1, a carried value is placed in bits 11:4 and bits 3:0 are 0.
- R7: Serial blocks sent back to back produce output blocks back to back with no gap. The bank being drained is never the bank being filled.
- R8: A start marker in the middle of a block restarts collection at bit 0. The partial block produces no output.
- R9: Once a block has drained and no further block has completed, `blk_start_o` is 0 and `coef_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears both banks |
| ser_bit_i | input | 1 | Compressed serial data bit |
| ser_start_i | input | 1 | High on the cycle carrying bit 0 of a block |
| scale_i | input | 1 | Widening mode: 0 sign-extend, 1 shift left by 4 |
| coef_o | output | 12 | Rebuilt coefficient, one position per cycle |
| blk_start_o | output | 1 | High with position 0 of each output block |

## Verification
The outputs come from registers through combinational selection. Inputs driven for cycle k are therefore captured at the following clock edge, and position p of a block whose start marker was driven in cycle s is visible in cycle s + 64 + p. The bench drives inputs and samples outputs on the falling edge, and it stores the expected value of every cycle in a table indexed by that offset. It compares every cycle, including idle ones, so an output that comes one cycle early or late, or a stray pulse, shows up as a mismatch against zero.

// File: rtl/coef_unpack_pkg.sv
`timescale 1ns/1ps
package coef_unpack_pkg;
  localparam int VAL_W    = 8;                  // width of a carried value
  localparam int COEF_W   = 12;                 // native coefficient width
  localparam int NSEL     = 8;                  // values carried per block
  localparam int BLK_LEN  = 64;                 // output positions per block
  localparam int BLK_ROW  = 8;                  // positions per block row
  localparam int SHIFT    = COEF_W - VAL_W;     // scale-mode left shift
  localparam int SER_BITS = NSEL * VAL_W;       // serial bits per block
  localparam int POS_W    = $clog2(BLK_LEN);
  localparam int SBIT_W   = $clog2(SER_BITS);
  localparam int SLOT_W   = $clog2(NSEL);
  localparam int VBIT_W   = $clog2(VAL_W);

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_t;

  // carried set: three columns of rows 0 and 1, two of row 2
  function automatic slot_t pos_to_slot(input logic [POS_W-1:0] pos);
    slot_t r;
    int row, col;
    row = int'(pos) / BLK_ROW;
    col = int'(pos) % BLK_ROW;
    r = '0;
    if (row < 2 && col < 3) begin
      r.hit  = 1'b1;
      r.slot = SLOT_W'(row * 3 + col);
    end else if (row == 2 && col < 2) begin
      r.hit  = 1'b1;
      r.slot = SLOT_W'(6 + col);
    end
    return r;
  endfunction
endpackage

// File: rtl/coef_unpack_collect.sv
`timescale 1ns/1ps
module coef_unpack_collect
  import coef_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit_i,
  input  logic              ser_start_i,
  output logic [1:0]        wr_en_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [VBIT_W-1:0] wr_bit_o,
  output logic              wr_val_o,
  output logic              done_o,
  output logic              fill_sel_o
);
  logic              busy;
  logic [SBIT_W-1:0] bidx;
  logic [SBIT_W-1:0] cur;
  logic              take;
  logic              wsel;

  assign cur       = ser_start_i ? '0 : bidx;
  assign take      = ser_start_i | busy;
  assign done_o    = take && (cur == SBIT_W'(SER_BITS - 1));
  assign wr_slot_o = cur[SBIT_W-1:VBIT_W];
  assign wr_bit_o  = VBIT_W'(VAL_W - 1) - cur[VBIT_W-1:0];
  assign wr_val_o  = ser_bit_i;
  assign wr_en_o   = {take & wsel, take & ~wsel};
  assign fill_sel_o = wsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      bidx <= '0;
      wsel <= 1'b0;
    end else if (ser_start_i) begin
      busy <= 1'b1;
      bidx <= SBIT_W'(1);
    end else if (busy) begin
      if (done_o) begin
        busy <= 1'b0;
        bidx <= '0;
        wsel <= ~wsel;
      end else begin
        bidx <= bidx + 1'b1;
      end
    end
  end

  // a marker always restarts at bit 1 next cycle
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start_i |=> (busy && bidx == SBIT_W'(1)));
  // completing a block switches the bank being filled
  assert_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (wsel != $past(wsel)));
endmodule

// File: rtl/coef_unpack_bank.sv
`timescale 1ns/1ps
module coef_unpack_bank
  import coef_unpack_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [SLOT_W-1:0]      slot_i,
  input  logic [VBIT_W-1:0]      bit_i,
  input  logic                   d_i,
  output logic [NSEL*VAL_W-1:0]  vals_o
);
  logic [VAL_W-1:0] mem [NSEL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEL; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[slot_i][bit_i] <= d_i;
    end
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_flat
    assign vals_o[g*VAL_W +: VAL_W] = mem[g];
  end
endmodule

// File: rtl/coef_unpack_expand.sv
`timescale 1ns/1ps
module coef_unpack_expand
  import coef_unpack_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done_i,
  input  logic                  fill_sel_i,
  input  logic [NSEL*VAL_W-1:0] bank0_i,
  input  logic [NSEL*VAL_W-1:0] bank1_i,
  input  logic                  scale_i,
  output logic [COEF_W-1:0]     coef_o,
  output logic                  blk_start_o
);
  logic             run;
  logic             rsel;
  logic [POS_W-1:0] ocnt;
  slot_t            sl;
  logic [VAL_W-1:0] v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      rsel <= 1'b0;
      ocnt <= '0;
    end else if (done_i) begin
      run  <= 1'b1;
      rsel <= fill_sel_i;
      ocnt <= '0;
    end else if (run) begin
      if (ocnt == POS_W'(BLK_LEN - 1)) run <= 1'b0;
      ocnt <= ocnt + 1'b1;
    end
  end

  always_comb begin
    sl = pos_to_slot(ocnt);
    v  = rsel ? bank1_i[sl.slot*VAL_W +: VAL_W] : bank0_i[sl.slot*VAL_W +: VAL_W];
    if (!run || !sl.hit)  coef_o = '0;
    else if (scale_i)     coef_o = {v, {SHIFT{1'b0}}};
    else                  coef_o = {{SHIFT{v[VAL_W-1]}}, v};
  end

  assign blk_start_o = run && (ocnt == '0);

  assert_sob_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start_o |=> !blk_start_o);
  assert_sob_after_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start_o |-> $past(done_i));
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (coef_o == '0 && !blk_start_o));
  assert_scale_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && scale_i) |-> (coef_o[SHIFT-1:0] == '0));
  assert_sign_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !scale_i) |-> (coef_o[COEF_W-1:VAL_W-1] == {(SHIFT+1){coef_o[VAL_W-1]}}));
  // the bank on the output is never the one being written
  assert_bank_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rsel != fill_sel_i));
endmodule

// File: rtl/coef_unpack.sv
`timescale 1ns/1ps
module coef_unpack
  import coef_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit_i,
  input  logic              ser_start_i,
  input  logic              scale_i,
  output logic [COEF_W-1:0] coef_o,
  output logic              blk_start_o
);
  logic [1:0]            wr_en;
  logic [SLOT_W-1:0]     wr_slot;
  logic [VBIT_W-1:0]     wr_bit;
  logic                  wr_val;
  logic                  done;
  logic                  fill_sel;
  logic [NSEL*VAL_W-1:0] bank_q [2];

  coef_unpack_collect u_collect (
    .clk(clk), .rst_n(rst_n), .ser_bit_i(ser_bit_i), .ser_start_i(ser_start_i),
    .wr_en_o(wr_en), .wr_slot_o(wr_slot), .wr_bit_o(wr_bit), .wr_val_o(wr_val),
    .done_o(done), .fill_sel_o(fill_sel)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    coef_unpack_bank u_bank (
      .clk(clk), .rst_n(rst_n), .we_i(wr_en[b]), .slot_i(wr_slot),
      .bit_i(wr_bit), .d_i(wr_val), .vals_o(bank_q[b])
    );
  end

  coef_unpack_expand u_expand (
    .clk(clk), .rst_n(rst_n), .done_i(done), .fill_sel_i(fill_sel),
    .bank0_i(bank_q[0]), .bank1_i(bank_q[1]), .scale_i(scale_i),
    .coef_o(coef_o), .blk_start_o(blk_start_o)
  );

  assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
endmodule

// File: tb/coef_unpack_tb.sv
`timescale 1ns/1ps
module coef_unpack_tb;
  localparam int NCYC = 900;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_bit_i = 1'b0;
  logic        ser_start_i = 1'b0;
  logic        scale_i = 1'b0;
  logic [11:0] coef_o;
  logic        blk_start_o;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  logic       st_bit  [NCYC];
  logic       st_sob  [NCYC];
  logic       st_mode [NCYC];
  logic       ex_sob  [NCYC];
  int         ex_kind [NCYC];   // 0 idle, 1 carried value, 2 forced zero
  logic [7:0] ex_val  [NCYC];
  int         ex_req  [NCYC];

  always #5 clk = ~clk;

  coef_unpack u_dut (
    .clk(clk), .rst_n(rst_n), .ser_bit_i(ser_bit_i), .ser_start_i(ser_start_i),
    .scale_i(scale_i), .coef_o(coef_o), .blk_start_o(blk_start_o)
  );

  // carried positions in stream order (R2)
  function automatic int slot_of(input int p);
    int tx [8] = '{0, 1, 2, 8, 9, 10, 16, 17};
    for (int j = 0; j < 8; j++) if (tx[j] == p) return j;
    return -1;
  endfunction

  function automatic logic [11:0] widen(input logic [7:0] v, input logic m);
    if (m) return {v, 4'h0};                    // R6
    return {{4{v[7]}}, v};                      // R5
  endfunction

  task automatic add_block(input int s, input logic [63:0] w, input int tag);
    for (int i = 0; i < 64; i++) begin
      st_sob[s+i] = (i == 0);
      st_bit[s+i] = w[63-i];                    // R2: value 0 first, MSB first
    end
    for (int p = 0; p < 64; p++) begin
      int o = s + 64 + p;                       // R3: 64-cycle offset
      int j = slot_of(p);
      ex_sob[o] = (p == 0);
      if (j >= 0) begin
        ex_kind[o] = 1;
        ex_val[o]  = w[63-8*j -: 8];
        ex_req[o]  = tag;
      end else begin
        ex_kind[o] = 2;
        ex_req[o]  = 4;                         // R4
      end
    end
  endtask

  task automatic add_partial(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      st_sob[s+i] = (i == 0);
      st_bit[s+i] = 1'($urandom);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < NCYC; k++) begin
      st_bit[k] = 1'b0; st_sob[k] = 1'b0;
      st_mode[k] = (k >= 280 && k < 620);
      ex_sob[k] = 1'b0; ex_kind[k] = 0; ex_val[k] = '0;
      ex_req[k] = (k < 74) ? 1 : 9;             // R1 before first block, R9 after
    end
    // directed extremes, mode 0 (R2, R5)
    add_block(10,  64'h7F80_01FF_0055_AA81, 5);
    add_block(74,  rnd64(), 7);                 // R7 back to back
    add_block(138, rnd64(), 7);
    add_partial(300, 30);                       // R8 aborted block
    add_block(330, 64'h80FF_7F01_00C3_3C81, 8); // R8 restart, mode 1
    add_block(394, rnd64(), 6);                 // R6
    add_block(458, rnd64(), 7);
    add_block(650, rnd64(), 2);                 // R2 random, mode 0
    add_block(714, rnd64(), 7);

    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (coef_o !== 12'h0 || blk_start_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: coef=%h sob=%b expected coef=000 sob=0", coef_o, blk_start_o);
    end
    rst_n = 1'b1;
    for (int k = 0; k < NCYC; k++) begin
      logic [11:0] e;
      @(negedge clk);
      e = (ex_kind[k] == 1) ? widen(ex_val[k], scale_i) : 12'h0;
      checks++;
      if (blk_start_o !== ex_sob[k]) begin
        failures++;
        $display("FAIL R3 cycle %0d: blk_start=%b expected %b", k, blk_start_o, ex_sob[k]);
      end else if (coef_o !== e) begin
        failures++;
        $display("FAIL R%0d cycle %0d: coef=%h expected %h", ex_req[k], k, coef_o, e);
      end
      ser_sob_drive(k);
    end
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic ser_sob_drive(input int k);
    ser_start_i = st_sob[k];
    ser_bit_i   = st_bit[k];
    scale_i     = st_mode[k];
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule